// File: doc/BRIEF.md
# Execution Mode and ROM Guard

This block sits beside a small CPU core and watches its memory bus. It decides whether the core is running boot firmware or a loaded application, and whether a syscall is in progress. After reset the core is in firmware mode, and it may fetch code from the boot ROM there. The first instruction fetch from any address outside the ROM puts the block into app mode. No register can set app mode. Only the fetch address changes it, and only a reset clears it.

An application asks for a firmware service by writing anywhere in a reserved 16 MB address window. The block answers with a one-cycle interrupt pulse and marks the syscall context as active. Once in app mode, a fetch from ROM is legal only inside that context. The context ends when the core pulses the return input.

The block also checks every access against the two protected memories. The ROM is 8 KB and the firmware RAM is 4 KB. Each sits at the base of a 16 MB aperture, and any access that lands in an aperture but beyond its memory is invalid. Any violation sets a trap flag, and the flag holds until reset.

Top module: `exec_mode_guard`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, app_mode, in_syscall, syscall_irq and trap are all 0.
- R2: In firmware mode, an instruction fetch from ROM (0x0000_0000 to 0x0000_1FFF) leaves app_mode at 0 and raises no trap.
- R3: An instruction fetch (bus_valid=1, bus_instr=1) from any address outside ROM sets app_mode to 1 one clock later. app_mode then stays 1 until reset, including across later ROM fetches.
- R4: A data access (bus_instr=0) never changes app_mode, whatever its address.
- R5: A write (bus_valid=1, bus_we=1) to any address from 0xE100_0000 to 0xE1FF_FFFF makes syscall_irq high for exactly one cycle, one clock later. Reads of that window and writes to 0xE0FF_FFFC or 0xE200_0000 produce no pulse.
- R6: in_syscall becomes 1 on the same edge as syscall_irq. A sys_return pulse clears it one clock later. If a syscall write arrives in the same cycle as sys_return, the write wins.
- R7: In app mode, with in_syscall=0, an instruction fetch from ROM sets trap one clock later. trap then stays 1 until reset.
- R8: In app mode, with in_syscall=1, an instruction fetch from ROM raises no trap.
- R9: In app mode, a data read from ROM raises no trap.
- R10: An access at 0x0000_2000 to 0x00FF_FFFF (beyond the ROM), or at 0xD000_1000 to 0xD0FF_FFFF (beyond the firmware RAM), sets trap one clock later. Accesses to 0x0000_1FFC and 0xD000_0FFC do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | A bus access is present this cycle |
| bus_instr | input | 1 | The access is an instruction fetch |
| bus_we | input | 1 | The access is a write |
| bus_addr | input | 32 | Byte address of the access |
| sys_return | input | 1 | Pulse that ends the syscall context |
| app_mode | output | 1 | 1 = app mode, 0 = firmware mode |
| in_syscall | output | 1 | A syscall context is active |
| syscall_irq | output | 1 | One-cycle syscall interrupt pulse |
| trap | output | 1 | Sticky flag for a violation |

## Verification
Every output is a register. Each result therefore appears exactly one clock edge after the cycle in which its bus access or return pulse is presented.

The bench drives each stimulus for a single cycle and checks the outputs 1 ns after the next rising edge. For syscall_irq, it checks once more after an idle cycle to confirm the pulse lasts one cycle. Because trap is sticky, the bench applies a fresh reset before each scenario that expects no trap.

// File: rtl/emg_pkg.sv
package emg_pkg;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned APER_BITS  = 24;
  localparam logic [31:0] ROM_BASE_D = 32'h0000_0000;
  localparam int unsigned ROM_SIZE_D = 8192;
  localparam logic [31:0] RAM_BASE_D = 32'hD000_0000;
  localparam int unsigned RAM_SIZE_D = 4096;
  localparam logic [31:0] SYS_BASE_D = 32'hE100_0000;

  typedef struct packed {
    logic in_aper;
    logic in_range;
  } region_hit_t;
endpackage

// File: rtl/emg_region_chk.sv
module emg_region_chk #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned APER_BITS = 24,
  parameter logic [31:0] BASE      = 32'h0,
  parameter int unsigned SIZE      = 4096
) (
  input  logic [ADDR_W-1:0] addr,
  output emg_pkg::region_hit_t hit
);
  localparam logic [APER_BITS:0] LIMIT = (APER_BITS+1)'(SIZE);
  localparam int unsigned TOP_W = ADDR_W - APER_BITS;

  logic [TOP_W-1:0]     tag;
  logic [APER_BITS-1:0] offset;

  assign tag    = addr[ADDR_W-1:APER_BITS];
  assign offset = addr[APER_BITS-1:0];

  always_comb begin
    hit.in_aper  = (tag == BASE[ADDR_W-1:APER_BITS]);
    hit.in_range = hit.in_aper && ({1'b0, offset} < LIMIT);
  end
endmodule

// File: rtl/emg_mode_ctl.sv
module emg_mode_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic fetch_outside,
  input  logic sys_hit,
  input  logic sys_return,
  output logic app_mode,
  output logic in_syscall,
  output logic syscall_irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      app_mode    <= 1'b0;
      in_syscall  <= 1'b0;
      syscall_irq <= 1'b0;
    end else begin
      if (fetch_outside) app_mode <= 1'b1;
      syscall_irq <= sys_hit;
      if (sys_hit) in_syscall <= 1'b1;
      else if (sys_return) in_syscall <= 1'b0;
    end
  end

  a_r3_app_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    app_mode |=> app_mode);
  a_r5_irq_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    sys_hit |=> syscall_irq);
  a_r6_ctx_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    syscall_irq |-> in_syscall);
  a_r6_ctx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_return && !sys_hit) |=> !in_syscall);
endmodule

// File: rtl/emg_trap_ctl.sv
module emg_trap_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic rom_exec_bad,
  input  logic range_bad,
  output logic trap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trap <= 1'b0;
    else if (rom_exec_bad || range_bad) trap <= 1'b1;
  end

  a_r7_trap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> trap);
  a_r10_range_traps: assert property (@(posedge clk) disable iff (!rst_n)
    range_bad |=> trap);
endmodule

// File: rtl/exec_mode_guard.sv
module exec_mode_guard #(
  parameter int unsigned ADDR_W    = emg_pkg::ADDR_W,
  parameter int unsigned APER_BITS = emg_pkg::APER_BITS,
  parameter logic [31:0] ROM_BASE  = emg_pkg::ROM_BASE_D,
  parameter int unsigned ROM_SIZE  = emg_pkg::ROM_SIZE_D,
  parameter logic [31:0] RAM_BASE  = emg_pkg::RAM_BASE_D,
  parameter int unsigned RAM_SIZE  = emg_pkg::RAM_SIZE_D,
  parameter logic [31:0] SYS_BASE  = emg_pkg::SYS_BASE_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_instr,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              sys_return,
  output logic              app_mode,
  output logic              in_syscall,
  output logic              syscall_irq,
  output logic              trap
);
  localparam int unsigned SYS_SIZE = 1 << APER_BITS;

  emg_pkg::region_hit_t rom_h, ram_h, sys_h;

  emg_region_chk #(.ADDR_W(ADDR_W), .APER_BITS(APER_BITS), .BASE(ROM_BASE), .SIZE(ROM_SIZE))
    u_rom (.addr(bus_addr), .hit(rom_h));
  emg_region_chk #(.ADDR_W(ADDR_W), .APER_BITS(APER_BITS), .BASE(RAM_BASE), .SIZE(RAM_SIZE))
    u_ram (.addr(bus_addr), .hit(ram_h));
  emg_region_chk #(.ADDR_W(ADDR_W), .APER_BITS(APER_BITS), .BASE(SYS_BASE), .SIZE(SYS_SIZE))
    u_sys (.addr(bus_addr), .hit(sys_h));

  logic fetch, fetch_outside, sys_hit, rom_exec_bad, range_bad;

  always_comb begin
    fetch         = bus_valid && bus_instr;
    fetch_outside = fetch && !rom_h.in_range;
    sys_hit       = bus_valid && bus_we && sys_h.in_aper && sys_h.in_range;
    rom_exec_bad  = fetch && rom_h.in_range && app_mode && !in_syscall;
    range_bad     = bus_valid && ((rom_h.in_aper && !rom_h.in_range) ||
                                  (ram_h.in_aper && !ram_h.in_range));
  end

  emg_mode_ctl u_mode (
    .clk(clk), .rst_n(rst_n), .fetch_outside(fetch_outside), .sys_hit(sys_hit),
    .sys_return(sys_return), .app_mode(app_mode), .in_syscall(in_syscall),
    .syscall_irq(syscall_irq)
  );

  emg_trap_ctl u_trap (
    .clk(clk), .rst_n(rst_n), .rom_exec_bad(rom_exec_bad), .range_bad(range_bad),
    .trap(trap)
  );

  a_r4_data_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (!app_mode && !(bus_valid && bus_instr)) |=> !app_mode);
  a_r2_fw_rom_fetch_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (!app_mode && !trap && bus_valid && bus_instr && rom_h.in_range) |=> (!app_mode && !trap));
endmodule

// File: tb/exec_mode_guard_tb_top.sv
`timescale 1ns/1ps
module exec_mode_guard_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_instr = 1'b0, bus_we = 1'b0, sys_return = 1'b0;
  logic [31:0] bus_addr = 32'h0;
  logic app_mode, in_syscall, syscall_irq, trap;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  exec_mode_guard dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_instr(bus_instr),
    .bus_we(bus_we), .bus_addr(bus_addr), .sys_return(sys_return),
    .app_mode(app_mode), .in_syscall(in_syscall), .syscall_irq(syscall_irq), .trap(trap)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic i, input logic w, input logic [31:0] a,
                      input logic ret);
    bus_valid = v; bus_instr = i; bus_we = w; bus_addr = a; sys_return = ret;
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_instr = 1'b0; bus_we = 1'b0; sys_return = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(posedge clk); #1;
    chk("R1 app_mode in reset", app_mode, 1'b0);
    chk("R1 trap in reset", trap, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 app_mode", app_mode, 1'b0);
    chk("R1 in_syscall", in_syscall, 1'b0);
    chk("R1 syscall_irq", syscall_irq, 1'b0);
    chk("R1 trap", trap, 1'b0);
  endtask

  task automatic t_fw_rom();
    do_reset();
    step(1, 1, 0, 32'h0000_0100, 0);
    chk("R2 app_mode", app_mode, 1'b0);
    step(1, 1, 0, 32'h0000_1FFC, 0);
    chk("R2 app_mode top", app_mode, 1'b0);
    chk("R2 trap", trap, 1'b0);
  endtask

  task automatic t_data_no_mode();
    do_reset();
    step(1, 0, 0, 32'h4000_0000, 0);
    chk("R4 read outside", app_mode, 1'b0);
    step(1, 0, 1, 32'hD000_0010, 0);
    chk("R4 write fwram", app_mode, 1'b0);
    chk("R4 no trap", trap, 1'b0);
  endtask

  task automatic t_enter_app();
    do_reset();
    step(1, 1, 0, 32'h4000_0000, 0);
    chk("R3 app set", app_mode, 1'b1);
    chk("R3 no trap", trap, 1'b0);
    step(1, 0, 0, 32'h0000_0040, 0);
    chk("R9 data read rom no trap", trap, 1'b0);
    chk("R3 stays", app_mode, 1'b1);
    step(1, 1, 0, 32'h0000_0040, 0);
    chk("R7 rom fetch trap", trap, 1'b1);
    chk("R3 still app", app_mode, 1'b1);
    step(0, 0, 0, 32'h0, 0);
    step(0, 0, 0, 32'h0, 0);
    chk("R7 trap sticky", trap, 1'b1);
  endtask

  task automatic t_syscall();
    do_reset();
    step(1, 1, 0, 32'h4000_0000, 0);
    step(1, 0, 0, 32'hE100_0000, 0);
    chk("R5 read no irq", syscall_irq, 1'b0);
    step(1, 0, 1, 32'hE0FF_FFFC, 0);
    chk("R5 below window", syscall_irq, 1'b0);
    step(1, 0, 1, 32'hE200_0000, 0);
    chk("R5 above window", syscall_irq, 1'b0);
    step(1, 0, 1, 32'hE1FF_FFFC, 0);
    chk("R5 irq pulse", syscall_irq, 1'b1);
    chk("R6 ctx set", in_syscall, 1'b1);
    step(1, 1, 0, 32'h0000_0080, 0);
    chk("R5 irq one cycle", syscall_irq, 1'b0);
    chk("R8 rom fetch in syscall", trap, 1'b0);
    step(0, 0, 0, 32'h0, 1);
    chk("R6 ctx cleared", in_syscall, 1'b0);
    step(1, 0, 1, 32'hE100_0000, 1);
    chk("R6 write wins", in_syscall, 1'b1);
    chk("R5 irq again", syscall_irq, 1'b1);
    chk("R8 no trap", trap, 1'b0);
  endtask

  task automatic t_ranges();
    do_reset();
    step(1, 0, 0, 32'h0000_1FFC, 0);
    chk("R10 rom top ok", trap, 1'b0);
    step(1, 0, 1, 32'hD000_0FFC, 0);
    chk("R10 ram top ok", trap, 1'b0);
    step(1, 0, 0, 32'h0000_2000, 0);
    chk("R10 past rom", trap, 1'b1);
    do_reset();
    step(1, 0, 1, 32'hD000_1000, 0);
    chk("R10 past ram", trap, 1'b1);
  endtask

  initial begin
    @(posedge clk); #1;
    t_reset();
    t_fw_rom();
    t_data_no_mode();
    t_enter_app();
    t_syscall();
    t_ranges();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule